// File: doc/BRIEF.md
# Two-Way Second-Level Cache Tag Lookup Controller

This block keeps the tags of an external second-level cache on chip and decides hit or miss before any external data RAM cycle starts. Because the tag compare finishes first, a cache built only from off-chip data SRAMs can still be two-way set associative. The core side presents a line address with a handshake. A fixed number of core cycles later the block returns hit or miss, the way, and whether the chosen victim holds modified data.

On a hit the block drives the SRAM address, which carries the way bit, together with enable and write strobes. It does this for every 64-bit beat of the 32-byte line. Each address is held for one full external clock period. The external interface runs at one-half or two-thirds of the core clock. This is done with a clock-enable pattern, not a second clock. Total capacity is one of three sizes, chosen when reset is applied. An invalidate-all request sweeps the tag store and keeps the block busy until the sweep ends.

Top module: `l2tag_lookup`

## Requirements
- R1: The capacity code `cfg_size_i` is sampled while `rst_i` is high. Code 0 gives BASE_SETS sets, code 1 gives twice as many and codes 2 and 3 give four times as many. The set index is the low 6, 7 or 8 bits of the line address (default BASE_SETS=64). The remaining higher bits form the tag.
- R2: After reset the block is busy for exactly 4*BASE_SETS cycles while it clears the store. `ack_o` stays low during this time and no response or SRAM strobe appears.
- R3: `ack_o` is high in a cycle where `req_i` is high, `inv_i` is low and the block is idle. `resp_valid_o` pulses for one cycle, two cycles after the acknowledged cycle.
- R4: A lookup hits when a valid way of the indexed set holds the request tag. `resp_way_o` then names that way and `resp_vdirty_o` is 0.
- R5: On a miss the victim is way 0 if that way is invalid, else way 1 if that way is invalid, else the way the set's LRU bit names. `resp_way_o` gives the victim and `resp_vdirty_o` is 1 when the victim was valid and dirty. The request tag is installed in the victim, and a miss starts no SRAM access.
- R6: After any hit or fill of way w, the LRU bit of that set names the other way.
- R7: A write request marks the hit or newly filled way dirty. A read fill leaves it clean, and a read hit leaves the dirty bit as it was.
- R8: A hit drives four SRAM beats with `sram_en_o` high. The address is {way, set index (8 bits), beat (2 bits)}, with the beat running from 0 to 3. `sram_we_o` equals the request's write flag. The block stays busy until the last beat ends.
- R9: The SRAM outputs change only on external clock ticks. In half mode a tick occurs every second core cycle. In two-thirds mode ticks occur in a repeating on, on, off pattern. A four-beat access therefore keeps `sram_en_o` high for 8 or 6 core cycles.
- R10: `inv_i` in an idle cycle takes priority over `req_i`. It starts a clear that keeps `busy_o` high for 4*BASE_SETS cycles, and afterwards every lookup misses with `resp_vdirty_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_i | input | 1 | Synchronous reset, active high |
| cfg_size_i | input | 2 | Capacity code, sampled during reset |
| cfg_half_i | input | 1 | 1: external clock is one-half of core; 0: two-thirds |
| req_i | input | 1 | Lookup request |
| req_line_i | input | ADDR_W-5 | Physical line address (byte address without offset) |
| req_wr_i | input | 1 | Request is a write |
| ack_o | output | 1 | Request accepted this cycle |
| inv_i | input | 1 | Invalidate every line |
| busy_o | output | 1 | Block is clearing, looking up or transferring |
| resp_valid_o | output | 1 | Lookup result valid (one cycle) |
| resp_hit_o | output | 1 | Lookup hit |
| resp_way_o | output | 1 | Hit way, or victim way on a miss |
| resp_vdirty_o | output | 1 | Victim holds modified data |
| sram_en_o | output | 1 | External SRAM enable |
| sram_we_o | output | 1 | External SRAM write |
| sram_addr_o | output | IDX_MAX+1+2 | External SRAM address {way, set, beat} |

## Verification
The assertions rely on three things about the inputs. The capacity and ratio codes change only while reset is high. A request keeps its address and write flag steady until it is acknowledged. `inv_i` is raised only when the block is idle. The stimulus changes inputs only at falling clock edges and holds each request until `ack_o` is seen. It sets the configuration in the same cycles that reset is applied. It raises invalidate only after the previous transfer has ended and `busy_o` has fallen.

// File: rtl/l2tag_pkg.sv
`timescale 1ns/1ps
package l2tag_pkg;
    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        SZ_BASE   = 2'd0,
        SZ_DOUBLE = 2'd1,
        SZ_QUAD   = 2'd2,
        SZ_QUAD_B = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_CLEAR,
        ST_IDLE,
        ST_LOOK,
        ST_XFER
    } state_e;

    function automatic logic [1:0] size_shift(size_e s);
        case (s)
            SZ_BASE:   return 2'd0;
            SZ_DOUBLE: return 2'd1;
            default:   return 2'd2;
        endcase
    endfunction
endpackage

// File: rtl/l2tag_tick.sv
`timescale 1ns/1ps
module l2tag_tick (
    input  logic clk_i,
    input  logic rst_i,
    input  logic half_i,
    output logic tick_o
);
    logic [1:0] cnt_d, cnt_q;

    always_comb begin
        if (half_i) begin
            cnt_d  = (cnt_q == 2'd1) ? 2'd0 : cnt_q + 2'd1;
            tick_o = (cnt_q == 2'd0);
        end else begin
            cnt_d  = (cnt_q == 2'd2) ? 2'd0 : cnt_q + 2'd1;
            tick_o = (cnt_q != 2'd2);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) cnt_q <= 2'd0;
        else       cnt_q <= cnt_d;
    end

    // R9
    half_tick_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        half_i && tick_o |=> !tick_o);

    // R9
    tick_gap_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick_o |=> tick_o);
endmodule

// File: rtl/l2tag_store.sv
`timescale 1ns/1ps
module l2tag_store #(
    parameter int SETS  = 256,
    parameter int REC_W = 47,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [REC_W-1:0] rd_rec_o,
    input  logic             we_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [REC_W-1:0] wr_rec_i
);
    logic [REC_W-1:0] mem_q [SETS];

    always_ff @(posedge clk_i) begin
        if (we_i) mem_q[wr_idx_i] <= wr_rec_i;
    end

    assign rd_rec_o = mem_q[rd_idx_i];
endmodule

// File: rtl/l2tag_match.sv
`timescale 1ns/1ps
module l2tag_match
    import l2tag_pkg::*;
#(
    parameter int TAG_W = 21,
    localparam int REC_W = 1 + WAYS * (TAG_W + 2)
) (
    input  logic [REC_W-1:0] rec_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [TAG_W-1:0] tag_mask_i,
    input  logic             wr_i,
    output logic             hit_o,
    output logic             way_o,
    output logic             vic_dirty_o,
    output logic [REC_W-1:0] rec_o
);
    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic [TAG_W-1:0] tag;
    } ent_t;

    typedef struct packed {
        logic              lru;
        ent_t [WAYS-1:0]   way;
    } rec_t;

    rec_t            cur, nxt;
    logic [WAYS-1:0] match;
    logic            hit_way, vic;

    assign cur = rec_t'(rec_i);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign match[w] = cur.way[w].valid &&
                          (((cur.way[w].tag ^ tag_i) & tag_mask_i) == '0);
    end

    always_comb begin
        hit_o   = |match;
        hit_way = match[1];
        if (!cur.way[0].valid)      vic = 1'b0;
        else if (!cur.way[1].valid) vic = 1'b1;
        else                        vic = cur.lru;
        vic_dirty_o = cur.way[vic].valid && cur.way[vic].dirty;
        way_o       = hit_o ? hit_way : vic;

        nxt = cur;
        if (hit_o) begin
            nxt.way[hit_way].dirty = cur.way[hit_way].dirty | wr_i;
            nxt.lru                = ~hit_way;
        end else begin
            nxt.way[vic].valid = 1'b1;
            nxt.way[vic].dirty = wr_i;
            nxt.way[vic].tag   = tag_i;
            nxt.lru            = ~vic;
        end
        rec_o = REC_W'(nxt);
    end
endmodule

// File: rtl/l2tag_lookup.sv
`timescale 1ns/1ps
module l2tag_lookup
    import l2tag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int DATA_W     = 64,
    parameter int BASE_SETS  = 64,
    localparam int OFF_W    = $clog2(LINE_BYTES),
    localparam int LINE_W   = ADDR_W - OFF_W,
    localparam int BEATS    = LINE_BYTES * 8 / DATA_W,
    localparam int BEAT_W   = $clog2(BEATS),
    localparam int IDX_MIN  = $clog2(BASE_SETS),
    localparam int IDX_MAX  = IDX_MIN + 2,
    localparam int SETS_MAX = BASE_SETS * 4,
    localparam int TAG_W    = LINE_W - IDX_MIN,
    localparam int SRAM_AW  = 1 + IDX_MAX + BEAT_W,
    localparam int REC_W    = 1 + WAYS * (TAG_W + 2)
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic [1:0]         cfg_size_i,
    input  logic               cfg_half_i,
    input  logic               req_i,
    input  logic [LINE_W-1:0]  req_line_i,
    input  logic               req_wr_i,
    output logic               ack_o,
    input  logic               inv_i,
    output logic               busy_o,
    output logic               resp_valid_o,
    output logic               resp_hit_o,
    output logic               resp_way_o,
    output logic               resp_vdirty_o,
    output logic               sram_en_o,
    output logic               sram_we_o,
    output logic [SRAM_AW-1:0] sram_addr_o
);
    typedef struct packed {
        state_e               st;
        size_e                size;
        logic                 half;
        logic [IDX_MAX-1:0]   clr_idx;
        logic [IDX_MAX-1:0]   set;
        logic [TAG_W-1:0]     tag;
        logic                 wr;
        logic                 rv;
        logic                 hit;
        logic                 way;
        logic                 vd;
        logic                 en;
        logic                 we;
        logic [BEAT_W-1:0]    beat;
        logic [SRAM_AW-1:0]   saddr;
    } regs_t;

    regs_t q, d;

    logic [1:0]         shift;
    logic [IDX_MAX-1:0] set_mask, req_set, wr_idx;
    logic [TAG_W-1:0]   tag_mask, req_tag;
    logic [REC_W-1:0]   rd_rec, upd_rec, wr_rec;
    logic               st_we, m_hit, m_way, m_vd, tick;

    l2tag_tick u_tick (
        .clk_i  (clk_i),
        .rst_i  (rst_i),
        .half_i (q.half),
        .tick_o (tick)
    );

    l2tag_store #(.SETS(SETS_MAX), .REC_W(REC_W)) u_store (
        .clk_i    (clk_i),
        .rd_idx_i (q.set),
        .rd_rec_o (rd_rec),
        .we_i     (st_we),
        .wr_idx_i (wr_idx),
        .wr_rec_i (wr_rec)
    );

    l2tag_match #(.TAG_W(TAG_W)) u_match (
        .rec_i       (rd_rec),
        .tag_i       (q.tag),
        .tag_mask_i  (tag_mask),
        .wr_i        (q.wr),
        .hit_o       (m_hit),
        .way_o       (m_way),
        .vic_dirty_o (m_vd),
        .rec_o       (upd_rec)
    );

    always_comb begin
        shift    = size_shift(q.size);
        set_mask = {IDX_MAX{1'b1}} >> (2'd2 - shift);
        tag_mask = {TAG_W{1'b1}} << shift;
        req_set  = req_line_i[IDX_MAX-1:0] & set_mask;
        req_tag  = req_line_i[LINE_W-1 -: TAG_W];
        ack_o    = (q.st == ST_IDLE) && req_i && !inv_i;

        d      = q;
        d.rv   = 1'b0;
        st_we  = 1'b0;
        wr_idx = q.set;
        wr_rec = upd_rec;

        case (q.st)
            ST_CLEAR: begin
                st_we     = 1'b1;
                wr_idx    = q.clr_idx;
                wr_rec    = '0;
                d.clr_idx = q.clr_idx + 1'b1;
                if (q.clr_idx == IDX_MAX'(SETS_MAX - 1)) d.st = ST_IDLE;
            end
            ST_IDLE: begin
                if (inv_i) begin
                    d.st      = ST_CLEAR;
                    d.clr_idx = '0;
                end else if (req_i) begin
                    d.st  = ST_LOOK;
                    d.set = req_set;
                    d.tag = req_tag;
                    d.wr  = req_wr_i;
                end
            end
            ST_LOOK: begin
                st_we = 1'b1;
                d.rv  = 1'b1;
                d.hit = m_hit;
                d.way = m_way;
                d.vd  = !m_hit && m_vd;
                d.st  = m_hit ? ST_XFER : ST_IDLE;
            end
            default: begin
                if (tick) begin
                    if (!q.en) begin
                        d.en    = 1'b1;
                        d.we    = q.wr;
                        d.beat  = '0;
                        d.saddr = {q.way, q.set, {BEAT_W{1'b0}}};
                    end else if (q.beat == BEAT_W'(BEATS - 1)) begin
                        d.en = 1'b0;
                        d.we = 1'b0;
                        d.st = ST_IDLE;
                    end else begin
                        d.beat  = q.beat + 1'b1;
                        d.saddr = {q.way, q.set, q.beat + 1'b1};
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            q      <= '0;
            q.st   <= ST_CLEAR;
            q.size <= size_e'(cfg_size_i);
            q.half <= cfg_half_i;
        end else begin
            q <= d;
        end
    end

    assign busy_o        = (q.st != ST_IDLE);
    assign resp_valid_o  = q.rv;
    assign resp_hit_o    = q.hit;
    assign resp_way_o    = q.way;
    assign resp_vdirty_o = q.vd;
    assign sram_en_o     = q.en;
    assign sram_we_o     = q.we;
    assign sram_addr_o   = q.saddr;

    // R3
    ack_lat_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        ack_o |-> ##2 resp_valid_o);

    // R9
    sram_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !tick |=> $stable(sram_addr_o) && $stable(sram_en_o));

    // R8
    sram_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        sram_en_o |-> busy_o);

    // R10
    inv_busy_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        inv_i && !busy_o |=> busy_o);
endmodule

// File: tb/test_l2tag_lookup.sv
`timescale 1ns/1ps
module test_l2tag_lookup;
    localparam int SETS_MAX = 256;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_size = 2'd0;
    logic        cfg_half = 1'b1;
    logic        req = 1'b0;
    logic [26:0] line = '0;
    logic        wr = 1'b0;
    logic        inv = 1'b0;
    logic        ack, busy, rv, hit, way, vd, en, we;
    logic [10:0] saddr;

    int checks = 0;
    int errors = 0;
    int cur_shift = 0;
    bit cur_half = 1'b1;
    bit done = 1'b0;

    always #4 clk = ~clk;

    l2tag_lookup i_l2tag_lookup (
        .clk_i(clk), .rst_i(rst), .cfg_size_i(cfg_size), .cfg_half_i(cfg_half),
        .req_i(req), .req_line_i(line), .req_wr_i(wr), .ack_o(ack),
        .inv_i(inv), .busy_o(busy), .resp_valid_o(rv), .resp_hit_o(hit),
        .resp_way_o(way), .resp_vdirty_o(vd), .sram_en_o(en), .sram_we_o(we),
        .sram_addr_o(saddr)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic        hit;
        logic        way;
        logic        vd;
    } vec_t;

    // byte address = tag << 11 | set << 5 at the base size
    localparam vec_t VECS [12] = '{
        '{32'h0000_0860, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 fill invalid way 0
        '{32'h0000_0860, 1'b0, 1'b1, 1'b0, 1'b0},  // R4 hit
        '{32'h0000_1060, 1'b1, 1'b0, 1'b1, 1'b0},  // R5 way 1 invalid, R7 write fill
        '{32'h0000_1060, 1'b0, 1'b1, 1'b1, 1'b0},  // R4
        '{32'h0000_0860, 1'b1, 1'b1, 1'b0, 1'b0},  // R7 write hit, R6 lru -> way 1
        '{32'h0000_1860, 1'b0, 1'b0, 1'b1, 1'b1},  // R6 victim way 1 dirty
        '{32'h0000_0860, 1'b0, 1'b1, 1'b0, 1'b0},  // R6 lru -> way 1
        '{32'h0000_2060, 1'b0, 1'b0, 1'b1, 1'b0},  // R7 read fill left clean
        '{32'h0000_1860, 1'b0, 1'b0, 1'b0, 1'b1},  // R6 victim way 0 dirty
        '{32'h0000_0880, 1'b0, 1'b0, 1'b0, 1'b0},  // R5 other set
        '{32'h0000_0880, 1'b0, 1'b1, 1'b0, 1'b0},  // R4
        '{32'h0000_2060, 1'b0, 1'b1, 1'b1, 1'b0}   // R4
    };

    task automatic chk(input bit ok, input string rq, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", rq, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic count_clear(input string rq);
        int cnt = 0;
        int acked = 0;
        while (busy) begin
            #1;
            if (ack) acked++;
            cnt++;
            @(negedge clk);
        end
        req = 1'b0;
        chk(cnt == SETS_MAX, rq, "busy cycles", cnt, SETS_MAX);
        chk(acked == 0, rq, "acks while busy", acked, 0);
    endtask

    task automatic do_reset(input logic [1:0] sz, input logic h);
        @(negedge clk);
        rst = 1'b1; cfg_size = sz; cfg_half = h; req = 1'b0; inv = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        cur_shift = (sz == 2'd0) ? 0 : (sz == 2'd1) ? 1 : 2;
        cur_half  = h;
        #1;
        chk(busy == 1'b1, "R2", "busy after reset", busy, 1);
        chk(rv == 1'b0, "R2", "resp_valid after reset", rv, 0);
        chk(en == 1'b0, "R2", "sram_en after reset", en, 0);
        req = 1'b1; line = '0;
        count_clear("R2");
    endtask

    task automatic do_req(input logic [31:0] a, input logic w, input logic eh,
                          input logic ew, input logic evd);
        int nb = 0;
        int ecyc = 0;
        int bad = 0;
        int last = -1;
        int exp_set, exp_a;
        bit prev = 1'b0;
        @(negedge clk);
        req = 1'b1; line = a[31:5]; wr = w;
        #1;
        while (!ack) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        req = 1'b0; wr = 1'b0;
        chk(rv == 1'b0, "R3", "resp_valid one cycle after ack", rv, 0);
        @(negedge clk);
        chk(rv == 1'b1, "R3", "resp_valid two cycles after ack", rv, 1);
        chk(hit == eh, "R4", "hit", hit, eh);
        chk(way == ew, eh ? "R4" : "R5", "way", way, ew);
        chk(vd == evd, "R5", "victim dirty", vd, evd);
        if (eh) begin
            exp_set = int'(a >> 5) & ((64 << cur_shift) - 1);
            while (busy) begin
                if (en) begin
                    ecyc++;
                    if (!prev || int'(saddr) != last) begin
                        exp_a = (int'(ew) << 10) | (exp_set << 2) | nb;
                        if (int'(saddr) != exp_a) begin
                            bad++;
                            $display("FAIL R8 beat %0d address actual %0d expected %0d",
                                     nb, saddr, exp_a);
                        end
                        if (we != w) bad++;
                        nb++;
                    end
                    last = int'(saddr);
                end
                prev = en;
                @(negedge clk);
            end
            chk(nb == 4, "R8", "beat count", nb, 4);
            chk(bad == 0, "R8", "beat address/write errors", bad, 0);
            chk(ecyc == (cur_half ? 8 : 6), "R9", "enable cycles", ecyc,
                cur_half ? 8 : 6);
        end else begin
            chk(busy == 1'b0 && en == 1'b0, "R5", "miss leaves idle", busy, 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        // R1 R2: base size, half ratio
        do_reset(2'd0, 1'b1);

        // R4 R5 R6 R7 R8 R9: table walk
        for (int i = 0; i < 12; i++)
            do_req(VECS[i].addr, VECS[i].wr, VECS[i].hit, VECS[i].way, VECS[i].vd);

        // R10: invalidate wins over a request, then everything misses
        @(negedge clk);
        inv = 1'b1; req = 1'b1; line = 27'(32'h2060 >> 5);
        #1;
        chk(ack == 1'b0, "R10", "ack with invalidate", ack, 0);
        @(negedge clk);
        inv = 1'b0; req = 1'b0;
        count_clear("R10");
        do_req(32'h0000_2060, 1'b0, 1'b0, 1'b0, 1'b0);  // R10
        do_req(32'h0000_1860, 1'b0, 1'b0, 1'b1, 1'b0);  // R10

        // R1: double size, address bit 11 is now index
        do_reset(2'd1, 1'b1);
        do_req(32'h0000_0860, 1'b0, 1'b0, 1'b0, 1'b0);  // R1 set 67
        do_req(32'h0000_1860, 1'b1, 1'b0, 1'b1, 1'b0);  // R1 same set 67
        do_req(32'h0000_0860, 1'b0, 1'b1, 1'b0, 1'b0);  // R1 R8
        do_req(32'h0000_0060, 1'b0, 1'b0, 1'b0, 1'b0);  // R1 set 3 separate

        // R1 R9: quad size (code 3), two-thirds ratio
        do_reset(2'd3, 1'b0);
        do_req(32'h0000_0060, 1'b0, 1'b0, 1'b0, 1'b0);  // R1 set 3
        do_req(32'h0000_0860, 1'b0, 1'b0, 1'b0, 1'b0);  // R1 set 67
        do_req(32'h0000_1060, 1'b1, 1'b0, 1'b0, 1'b0);  // R1 set 131
        do_req(32'h0000_0860, 1'b0, 1'b1, 1'b0, 1'b0);  // R9 six-cycle burst
        do_req(32'h0000_1060, 1'b1, 1'b1, 1'b0, 1'b0);  // R8 write beats
        do_req(32'h0000_0060, 1'b0, 1'b1, 1'b0, 1'b0);  // R1

        finish_run();
    end
endmodule